// File: doc/BRIEF.md
# Display power sequencer with frame guard

This block drives the internal power-enable line of a display controller. Software writes an 8-bit control word. Bit 0 of the word is the requested power state. Bits 7:1 give a guard time counted in frames. The timing generator supplies a one-cycle frame-start strobe. The power output takes the new state only after the programmed number of whole frames has passed since the write. The delay applies when power goes on and when it goes off. This gives the upstream DMA time to fill the pixel FIFOs before any data reaches the panel.

A busy flag is high while a change is pending. The last written word can be read back at all times. While power is off, the panel data pins are held at zero, so the panel sees no activity until the sequencer releases it. A guard field of zero counts as one frame, which keeps the minimum delay at one frame. A new write made during a pending delay replaces it.

Top module: `lcd_pwr_seq`

## Requirements
- R1: While rst_ni is low, pwr_o, busy_o and ctrl_rdata_o are all 0.
- R2: One cycle after a write (wr_en_i high at a clock edge), ctrl_rdata_o equals the written word, and it holds that value until the next write.
- R3: A write whose bit 0 differs from pwr_o sets busy_o high from the next cycle.
- R4: With guard field G = bits 7:1 of the written word (G ≥ 1), pwr_o takes the requested bit in the cycle after the clock edge at which the G-th frame_start_i pulse following the write is sampled. This holds for switching on and for switching off.
- R5: A guard field of 0 behaves as 1: the first frame_start_i pulse after the write completes the change.
- R6: A frame_start_i pulse sampled in the same cycle as a write does not count toward that write's guard. Pulses sampled while busy_o is low have no effect on pwr_o.
- R7: A write made while busy_o is high restarts the guard with the new count and the new requested state.
- R8: A write whose bit 0 equals the current pwr_o leaves pwr_o unchanged, cancels any pending change, and drives busy_o low from the next cycle.
- R9: panel_o equals panel_i while pwr_o is 1, and is all zeros while pwr_o is 0.
- R10: busy_o falls in the same cycle that pwr_o changes, and pwr_o never changes while busy_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 8 | Control word: bit 0 requested state, bits 7:1 guard frames |
| frame_start_i | input | 1 | One-cycle frame-start pulse |
| panel_i | input | 24 | Pixel and control data toward the panel |
| ctrl_rdata_o | output | 8 | Last written control word |
| pwr_o | output | 1 | Display power enable |
| busy_o | output | 1 | Change pending |
| panel_o | output | 24 | Panel pins, forced to zero while power is off |

## Verification
The results become visible at different times. Read-back and busy_o appear one cycle after the write edge. pwr_o changes one cycle after the edge at which the last counted frame pulse is sampled. panel_o is combinational and follows pwr_o and panel_i in the same cycle. The bench drives each input on the falling edge and updates its expected state at the next rising edge, using the inputs sampled at that edge. It then compares every output at the following falling edge, so each comparison falls in the first cycle in which the new value is due. Directed sequences count the strobes one at a time. They confirm that pwr_o stays unchanged through pulse G-1 and switches exactly after pulse G.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_e;

  function automatic int unsigned floor_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction
endpackage

// File: rtl/lcd_pwr_guard_cnt.sv
module lcd_pwr_guard_cnt
  import lcd_pwr_pkg::*;
#(
  parameter int GUARD_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [GUARD_W-1:0] load_val_i,
  input  logic               clear_i,
  input  logic               tick_i,
  output logic               active_o,
  output logic               expire_o
);
  localparam logic [GUARD_W-1:0] ONE = GUARD_W'(1);

  seq_state_e         state_q;
  logic [GUARD_W-1:0] cnt_q;
  logic [GUARD_W-1:0] floor_val;

  assign floor_val = (load_val_i == '0) ? ONE : load_val_i;
  assign active_o  = (state_q == SEQ_WAIT);
  // a write in the same cycle wins over the strobe
  assign expire_o  = active_o && tick_i && !load_i && !clear_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else if (load_i) begin
      state_q <= SEQ_WAIT;
      cnt_q   <= floor_val;
    end else if (clear_i) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else if (active_o && tick_i) begin
      if (cnt_q == ONE) begin
        state_q <= SEQ_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  p_cnt_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> cnt_q != '0);

  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> active_o && (cnt_q >= ONE) && (($past(load_val_i) == '0) || (cnt_q == $past(load_val_i))));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !load_i) |=> !active_o);
endmodule

// File: rtl/lcd_pwr_pin_gate.sv
module lcd_pwr_pin_gate #(
  parameter int PIX_W = 24
) (
  input  logic             en_i,
  input  logic [PIX_W-1:0] pins_i,
  output logic [PIX_W-1:0] pins_o
);
  for (genvar b = 0; b < PIX_W; b++) begin : g_bit
    assign pins_o[b] = pins_i[b] & en_i;
  end
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lcd_pwr_pkg::*;
#(
  parameter int GUARD_W = 7,
  parameter int PIX_W   = 24,
  localparam int CTRL_W = GUARD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              frame_start_i,
  input  logic [PIX_W-1:0]  panel_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  output logic              pwr_o,
  output logic              busy_o,
  output logic [PIX_W-1:0]  panel_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              tgt_q;
  logic              pwr_q;
  logic              req;
  logic              load;
  logic              clear;
  logic              expire;
  logic              active;

  assign req   = wr_data_i[0];
  assign load  = wr_en_i && (req != pwr_q);
  assign clear = wr_en_i && (req == pwr_q);

  lcd_pwr_guard_cnt #(.GUARD_W(GUARD_W)) u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (wr_data_i[CTRL_W-1:1]),
    .clear_i    (clear),
    .tick_i     (frame_start_i),
    .active_o   (active),
    .expire_o   (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tgt_q  <= 1'b0;
      pwr_q  <= 1'b0;
    end else begin
      if (wr_en_i) ctrl_q <= wr_data_i;
      if (load)    tgt_q  <= req;
      if (expire)  pwr_q  <= tgt_q;
    end
  end

  lcd_pwr_pin_gate #(.PIX_W(PIX_W)) u_gate (
    .en_i   (pwr_q),
    .pins_i (panel_i),
    .pins_o (panel_o)
  );

  assign ctrl_rdata_o = ctrl_q;
  assign pwr_o        = pwr_q;
  assign busy_o       = active;

  p_readback_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ctrl_rdata_o == $past(wr_data_i));

  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[0] != pwr_o) |=> busy_o);

  p_pwr_on_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_o != $past(pwr_o)) |-> $past(frame_start_i && busy_o && !wr_en_i));

  p_equal_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[0] == pwr_o) |=> !busy_o && $stable(pwr_o));

  p_busy_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_o != $past(pwr_o)) |-> !busy_o);

  p_pins_dark_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_o |-> panel_o == '0);
endmodule

// File: tb/lcd_pwr_seq_tb_top.sv
module lcd_pwr_seq_tb_top;
  localparam int GW = 7;
  localparam int CW = GW + 1;
  localparam int PW = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [CW-1:0] wr_data_i = '0;
  logic          frame_start_i = 1'b0;
  logic [PW-1:0] panel_i = '0;
  logic [CW-1:0] ctrl_rdata_o;
  logic          pwr_o;
  logic          busy_o;
  logic [PW-1:0] panel_o;

  int checks = 0;
  int fails = 0;

  // expected state
  logic [CW-1:0] m_ctrl = '0;
  logic          m_pwr = 1'b0;
  logic          m_busy = 1'b0;
  logic          m_tgt = 1'b0;
  int            m_left = 0;

  always #2 clk_i = ~clk_i;

  lcd_pwr_seq #(.GUARD_W(GW), .PIX_W(PW)) dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .frame_start_i, .panel_i,
    .ctrl_rdata_o, .pwr_o, .busy_o, .panel_o
  );

  function automatic logic [PW-1:0] exp_panel(input logic p, input logic [PW-1:0] d);
    return p ? d : '0;
  endfunction

  function automatic int guard_of(input logic [CW-1:0] w);
    return (w[CW-1:1] == 0) ? 1 : int'(w[CW-1:1]);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(ctrl_rdata_o == m_ctrl, "R2 readback", ctrl_rdata_o, m_ctrl);
    chk(busy_o == m_busy, "R3 busy", busy_o, m_busy);
    chk(pwr_o == m_pwr, "R4 power", pwr_o, m_pwr);
    chk(panel_o == exp_panel(m_pwr, panel_i), "R9 panel", panel_o, exp_panel(m_pwr, panel_i));
  endtask

  // one cycle: drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(input bit we, input logic [CW-1:0] wd, input bit fs);
    wr_en_i = we;
    wr_data_i = wd;
    frame_start_i = fs;
    panel_i = PW'($urandom);
    @(posedge clk_i);
    if (we) begin
      m_ctrl = wd;
      if (wd[0] != m_pwr) begin
        m_busy = 1'b1;
        m_tgt = wd[0];
        m_left = guard_of(wd);
      end else begin
        m_busy = 1'b0;
      end
    end else if (fs && m_busy) begin
      if (m_left == 1) begin
        m_pwr = m_tgt;
        m_busy = 1'b0;
      end else begin
        m_left--;
      end
    end
    @(negedge clk_i);
    check_all();
  endtask

  function automatic logic [CW-1:0] word(input int g, input bit p);
    return {GW'(g), p};
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    chk(pwr_o == 1'b0, "R1 reset pwr", pwr_o, 0);
    chk(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
    chk(ctrl_rdata_o == '0, "R1 reset readback", ctrl_rdata_o, 0);
    rst_ni = 1'b1;
    cyc(0, '0, 0);

    // R6: strobes while idle do nothing
    cyc(0, '0, 1); cyc(0, '0, 1);
    chk(pwr_o == 0, "R6 idle strobe", pwr_o, 0);

    // R4: power on, guard 3; strobe together with the write is not counted (R6)
    cyc(1, word(3, 1), 1);
    chk(busy_o == 1, "R3 busy after write", busy_o, 1);
    cyc(0, '0, 1); cyc(0, '0, 0); cyc(0, '0, 1);
    chk(pwr_o == 0, "R4 before last frame", pwr_o, 0);
    cyc(0, '0, 1);
    chk(pwr_o == 1, "R4 power on after G frames", pwr_o, 1);
    chk(busy_o == 0, "R10 busy drops with change", busy_o, 0);

    // R5: guard 0 for power off -> one frame
    cyc(1, word(0, 0), 0);
    cyc(0, '0, 0);
    chk(pwr_o == 1, "R5 waiting for frame", pwr_o, 1);
    cyc(0, '0, 1);
    chk(pwr_o == 0, "R5 zero guard acts as one", pwr_o, 0);

    // R7: restart while pending
    cyc(1, word(2, 1), 0);
    cyc(0, '0, 1);
    cyc(1, word(4, 1), 0);
    cyc(0, '0, 1); cyc(0, '0, 1); cyc(0, '0, 1);
    chk(pwr_o == 0, "R7 restarted count", pwr_o, 0);
    cyc(0, '0, 1);
    chk(pwr_o == 1, "R7 new count done", pwr_o, 1);

    // R8: equal request cancels pending
    cyc(1, word(2, 0), 0);
    cyc(1, word(5, 1), 0);
    chk(busy_o == 0, "R8 cancel pending", busy_o, 0);
    cyc(0, '0, 1); cyc(0, '0, 1); cyc(0, '0, 1);
    chk(pwr_o == 1, "R8 no change", pwr_o, 1);

    // R4 long guard, max value
    cyc(1, word(127, 0), 0);
    for (int i = 0; i < 126; i++) cyc(0, '0, 1);
    chk(pwr_o == 1, "R4 max guard pending", pwr_o, 1);
    cyc(0, '0, 1);
    chk(pwr_o == 0, "R4 max guard done", pwr_o, 0);

    // random phase
    for (int i = 0; i < 20000; i++) begin
      bit we;
      logic [CW-1:0] wd;
      we = ($urandom_range(0, 19) == 0);
      wd = ($urandom_range(0, 7) == 0) ? CW'($urandom) : word($urandom_range(0, 4), 1'($urandom));
      cyc(we, wd, $urandom_range(0, 3) == 0);
    end

    // R1: async reset mid-operation
    cyc(1, word(5, ~m_pwr), 0);
    #1 rst_ni = 1'b0;
    #1;
    chk(pwr_o == 0 && busy_o == 0 && ctrl_rdata_o == 0, "R1 reset clears", {pwr_o, busy_o, ctrl_rdata_o}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule